// File: doc/BRIEF.md
# SPI Register Access Bridge

This block is a SPI target that gives an external host read and write access to a sparse space of 1024 eight-bit registers. It turns each 24-bit serial frame into single-cycle transfers on a simple parallel register bus. That bus has an address, write data, a write strobe, a read strobe and read data returned one cycle after the read strobe.

The host clock, chip select and serial input are brought into the faster system clock through synchronizers, and all decoding runs in the system clock domain. The SPI clock must run no faster than one quarter of the system clock.

While chip select is held low, a write frame can be followed by more write packets, up to a limit. A read frame can be followed by more data bytes from the next addresses in turn. The serial output has its own enable, so that pad logic can release the line whenever the target is not selected.

Top module: `spi_reg_bridge`

## Requirements
- R1: A frame is 24 bits, sent MSB first and sampled on falling SPI clock edges (mode 1, clock idles low). Bit 23 is the direction, bits 22..13 are the register address, bits 12..8 are unused, and bits 7..0 are the data. A direction bit of 1 writes the data byte to the addressed register.
- R2: A write packet produces exactly one write strobe. The strobe comes on the 24th falling edge of the packet, and none comes after the first 23 edges.
- R3: A direction bit of 0 issues a read of the addressed register. During frame bits 23..8 the serial output carries zeros. During bits 7..0 it carries the register byte, MSB first.
- R4: The serial output changes only after rising SPI clock edges, so it is stable from each falling edge until the next rising edge.
- R5: The output enable is low whenever chip select is high and high whenever chip select is low. The serial output is held at zero while the target is deselected.
- R6: While chip select stays low after a write frame, each further 24-bit packet is a write to its own address, whatever its direction bit says. Only the first eight packets in one selection are committed. Later packets produce no strobe and leave every register unchanged.
- R7: While chip select stays low after a read frame, each further group of 8 clocks shifts out the byte at the next address. The address wraps from 1023 to 0.
- R8: Raising chip select in the middle of a packet discards that packet without a strobe. The next selection starts again at frame bit 23.
- R9: After reset, neither strobe is active, the output enable is low and the serial output is zero.
- R10: Serial input during the data field of a read, and during continuation bytes, never produces a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Enable for the serial output driver |
| bus_addr_o | output | 10 | Register bus address |
| bus_wdata_o | output | 8 | Register bus write data |
| bus_we_o | output | 1 | Register bus write strobe, one cycle |
| bus_re_o | output | 1 | Register bus read strobe, one cycle |
| bus_rdata_i | input | 8 | Register bus read data, valid the cycle after the read strobe |

## Verification
A falling SPI clock edge reaches the decode logic two system cycles after it happens. The write strobe is therefore high in the third system cycle after the edge. A change on the serial output shows up three cycles after a rising edge. The bench holds each SPI clock phase for four system cycles, so the serial output is sampled only after it has settled. Strobe counts and register contents are examined two extra cycles after the relevant edge. For R4 the bench samples the serial output at each falling edge and again just before the next rising edge, and the two samples must agree.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
    localparam int SPI_FRAME_BITS = 24;
    localparam int SPI_ADDR_W     = 10;
    localparam int SPI_DATA_W     = 8;
    localparam int SPI_GAP_BITS   = 5;
    localparam int SPI_MAX_PKTS   = 8;
    localparam int SPI_SYNC_DEPTH = 2;
endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q, prev_d;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
    parameter int FRAME_BITS = 24,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int GAP_BITS   = 5,
    parameter int MAX_PKTS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              cs_idle_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_re_o,
    output logic              miso_o
);
    localparam int CNT_W     = $clog2(FRAME_BITS);
    localparam int PKT_W     = $clog2(MAX_PKTS + 1);
    localparam int DATA_POS  = 1 + ADDR_W + GAP_BITS;
    localparam int LAST_POS  = FRAME_BITS - 1;
    localparam int KEEP_W    = ADDR_W + DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [PKT_W-1:0]   pkt;
        logic               rd_mode;
        logic [KEEP_W-2:0]  sh;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic               we;
        logic               re;
        logic               cap;
        logic [DATA_W-1:0]  rbuf;
        logic [DATA_W-1:0]  tx;
        logic               miso;
    } eng_state_t;

    eng_state_t q, d;
    logic [KEEP_W-1:0] word;
    logic              keep_bit;

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.re   = 1'b0;
        d.cap  = q.re;
        word   = {q.sh, mosi_i};
        keep_bit = ((q.cnt >= CNT_W'(1)) && (q.cnt <= CNT_W'(ADDR_W))) ||
                   (q.cnt >= CNT_W'(DATA_POS));
        if (q.cap) d.rbuf = bus_rdata_i;

        if (cs_idle_i) begin
            d.cnt     = '0;
            d.pkt     = '0;
            d.rd_mode = 1'b0;
            d.tx      = '0;
            d.miso    = 1'b0;
        end else begin
            if (sclk_fall_i) begin
                if (keep_bit) d.sh = word[KEEP_W-2:0];
                if (q.cnt == '0 && q.pkt == '0) d.rd_mode = ~mosi_i;
                if (q.rd_mode && q.cnt == CNT_W'(ADDR_W)) begin
                    d.addr = word[ADDR_W-1:0];
                    d.re   = 1'b1;
                end
                if (q.cnt == CNT_W'(LAST_POS)) begin
                    if (q.rd_mode) begin
                        d.cnt = CNT_W'(DATA_POS);
                    end else begin
                        d.cnt = '0;
                        if (q.pkt < PKT_W'(MAX_PKTS)) begin
                            d.we    = 1'b1;
                            d.addr  = word[KEEP_W-1:DATA_W];
                            d.wdata = word[DATA_W-1:0];
                            d.pkt   = q.pkt + 1'b1;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            if (sclk_rise_i) begin
                if (q.rd_mode && q.cnt == CNT_W'(DATA_POS)) begin
                    d.tx   = q.rbuf;
                    d.addr = q.addr + 1'b1;
                    d.re   = 1'b1;
                end else begin
                    d.tx = {q.tx[DATA_W-2:0], 1'b0};
                end
                d.miso = d.tx[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_addr_o  = q.addr;
    assign bus_wdata_o = q.wdata;
    assign bus_we_o    = q.we;
    assign bus_re_o    = q.re;
    assign miso_o      = q.miso;

    // R1: bit position never leaves the frame
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(LAST_POS));

    // R2: write strobe lasts one cycle
    p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    // R4: serial output moves only after a rising edge or a deselect
    p_miso_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.miso != $past(q.miso)) |-> $past(sclk_rise_i || cs_idle_i));

    // R5: deselect silences output and strobes
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle_i |=> (!q.miso && !q.we && !q.re));

    // R6: committed packets stay within the burst limit
    p_pkt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> (q.pkt != '0 && q.pkt <= PKT_W'(MAX_PKTS)));

    // R10: no write strobe in a read selection
    p_no_write_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> !q.rd_mode);

    // R3: read and write strobes never coincide
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.we && q.re));
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
    import spi_bridge_pkg::*;
#(
    parameter int FRAME_BITS  = SPI_FRAME_BITS,
    parameter int ADDR_W      = SPI_ADDR_W,
    parameter int DATA_W      = SPI_DATA_W,
    parameter int GAP_BITS    = SPI_GAP_BITS,
    parameter int MAX_PKTS    = SPI_MAX_PKTS,
    parameter int SYNC_STAGES = SPI_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_re_o,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    localparam int          PIN_CNT  = 3;
    localparam logic [PIN_CNT-1:0] PIN_RST = 3'b010;

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_sync;
    logic               sclk_rise;
    logic               sclk_fall;

    assign pins_raw = {mosi_i, cs_n_i, sclk_i};

    spi_sync_chain #(
        .WIDTH   (PIN_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_sync)
    );

    spi_edge_det u_sclk_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pins_sync[0]),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    spi_frame_engine #(
        .FRAME_BITS (FRAME_BITS),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .GAP_BITS   (GAP_BITS),
        .MAX_PKTS   (MAX_PKTS)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .cs_idle_i   (pins_sync[1]),
        .mosi_i      (pins_sync[2]),
        .bus_rdata_i (bus_rdata_i),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_we_o    (bus_we_o),
        .bus_re_o    (bus_re_o),
        .miso_o      (miso_o)
    );

    assign miso_oe_o = ~cs_n_i;
endmodule

// File: tb/spi_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module spi_reg_bridge_tb_top;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sclk, cs_n, mosi;
    logic       miso, miso_oe;
    logic [9:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       bus_we, bus_re;

    logic [7:0] mem     [1024];
    logic [7:0] exp_mem [1024];
    int checks = 0, errors = 0, we_cnt = 0, stab_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_reg_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_we_o(bus_we), .bus_re_o(bus_re),
        .bus_rdata_i(bus_rdata)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] pat(input int a, input int s);
        return 8'((a * 29 + s * 53 + 7) % 256);
    endfunction

    // register fabric model: write on strobe, read data one cycle after strobe
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 1024; a++) mem[a] <= init_val(a);
            bus_rdata <= 8'h00;
        end else begin
            if (bus_we) begin
                mem[bus_addr] <= bus_wdata;
                we_cnt++;
            end
            if (bus_re) bus_rdata <= mem[bus_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic spi_bit(input logic b, output logic r);
        sclk = 1'b1;
        mosi = b;
        repeat (H) @(negedge clk);
        r = miso;
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        if (miso !== r) stab_err++;
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_end();
        cs_n = 1'b1;
        repeat (3 * H) @(negedge clk);
    endtask

    task automatic write_burst(input int base, input int n, input int salt);
        logic r;
        cs_begin();
        for (int k = 0; k < n; k++) begin
            int a;
            logic [7:0] dv;
            logic [23:0] f;
            a  = (base + k) % 1024;
            dv = pat(a, salt);
            f  = {(k == 0) ? 1'b1 : 1'(k % 2), 10'(a), 5'b0, dv};
            for (int i = 23; i >= 0; i--) spi_bit(f[i], r);
            if (k < 8) exp_mem[a] = dv;
        end
        cs_end();
    endtask

    task automatic read_burst(input int base, input int n);
        logic [23:0] f, got;
        logic [7:0]  byt;
        logic        r;
        int          w0;
        w0 = we_cnt;
        f  = {1'b0, 10'(base), 13'h1FFF};
        cs_begin();
        for (int i = 23; i >= 0; i--) begin
            spi_bit(f[i], r);
            got[i] = r;
        end
        check(got[23:8] == 16'h0, "R3 zero header", int'(got[23:8]), 0);
        check(got[7:0] == exp_mem[base % 1024], "R3 read data",
              int'(got[7:0]), int'(exp_mem[base % 1024]));
        for (int k = 1; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                spi_bit(1'b1, r);
                byt[i] = r;
            end
            check(byt == exp_mem[(base + k) % 1024], "R7 auto-increment",
                  int'(byt), int'(exp_mem[(base + k) % 1024]));
        end
        cs_end();
        check(we_cnt == w0, "R10 no write during read", we_cnt, w0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] f;
        logic        r;
        int          w0;
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        for (int a = 0; a < 1024; a++) exp_mem[a] = init_val(a);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 reset state
        check(!bus_we && !bus_re, "R9 strobes idle", {bus_we, bus_re}, 0);
        check(miso_oe == 1'b0, "R9 output enable", miso_oe, 0);
        check(miso == 1'b0, "R9 serial output", miso, 0);

        // R5 output enable follows chip select
        cs_n = 1'b0; @(negedge clk);
        check(miso_oe == 1'b1, "R5 enable when selected", miso_oe, 1);
        cs_n = 1'b1; @(negedge clk);
        check(miso_oe == 1'b0, "R5 release when deselected", miso_oe, 0);
        repeat (3 * H) @(negedge clk);
        check(miso == 1'b0, "R5 output zero when deselected", miso, 0);

        // R2 commit timing on the 24th falling edge
        w0 = we_cnt;
        f  = {1'b1, 10'd512, 5'b0, 8'h3C};
        cs_begin();
        for (int i = 23; i >= 1; i--) spi_bit(f[i], r);
        repeat (2) @(negedge clk);
        check(we_cnt == w0, "R2 no strobe before last edge", we_cnt, w0);
        spi_bit(f[0], r);
        repeat (2) @(negedge clk);
        check(we_cnt == w0 + 1, "R2 single strobe at last edge", we_cnt, w0 + 1);
        cs_end();
        exp_mem[512] = 8'h3C;
        check(mem[512] == 8'h3C, "R1 write data", int'(mem[512]), 'h3C);

        // R8 abort mid-packet, then a fresh frame
        w0 = we_cnt;
        f  = {1'b1, 10'd513, 5'b0, 8'h77};
        cs_begin();
        for (int i = 23; i >= 4; i--) spi_bit(f[i], r);
        cs_end();
        check(we_cnt == w0, "R8 aborted packet discarded", we_cnt, w0);
        f = {1'b1, 10'd513, 5'b0, 8'h81};
        cs_begin();
        for (int i = 23; i >= 0; i--) spi_bit(f[i], r);
        cs_end();
        exp_mem[513] = 8'h81;
        check(we_cnt == w0 + 1, "R8 fresh frame strobe", we_cnt, w0 + 1);
        check(mem[513] == 8'h81, "R8 fresh frame data", int'(mem[513]), 'h81);

        // R1 R6 sweep: 32 full bursts across the 1023 to 0 boundary
        for (int b = 0; b < 32; b++) begin
            w0 = we_cnt;
            write_burst((1000 + 8 * b) % 1024, 8, b + 1);
            check(we_cnt == w0 + 8, "R6 eight packets committed", we_cnt, w0 + 8);
        end
        for (int k = 0; k < 256; k++) begin
            int a;
            a = (1000 + k) % 1024;
            check(mem[a] == exp_mem[a], "R1 burst write data", int'(mem[a]), int'(exp_mem[a]));
        end

        // R6 packets beyond the eighth are ignored
        w0 = we_cnt;
        write_burst(300, 10, 77);
        check(we_cnt == w0 + 8, "R6 burst cap", we_cnt, w0 + 8);

        // R3 R6 R7 R10 readback through the serial interface
        read_burst(300, 10);
        read_burst(512, 2);
        read_burst(1000, 256);

        check(stab_err == 0, "R4 output stable across falling edge", stab_err, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule